// File: doc/BRIEF.md
# Trace Fill Unit

The trace fill unit assembles a new trace line after the trace cache misses. A miss pulse carries the PC where the trace begins, and that PC becomes the line tag. From then on the unit takes the fetch groups that the ordinary instruction cache path delivers, in dynamic order. Each group ends at its first predicted-taken branch, and the next group continues at the predicted target. The unit appends instructions to the line and notes the predicted direction of every branch it absorbs.

Collection stops as soon as the line holds `N_INSTR` instructions or `M_BR` branches, whichever comes first. Only then does the unit work out where fetch must resume: a target address and a fall-through address, both taken from the last accepted instruction. It then presents the complete line for a single cycle. An abort input throws away a partial line without writing it. The unit accepts a new miss in the same cycle in which it presents the finished line.

Top module: `trace_fill_unit`

## Requirements
- R1: While reset is held and right after it, `busy_o` and `wr_valid_o` are 0.
- R2: A miss pulse with no abort starts a collection. `busy_o` is 1 from the next cycle, and the written line carries the miss PC as `wr_tag_o`.
- R3: Accepted instructions fill line entries in order (entry i at bits `[i*INSTR_W +: INSTR_W]`), across successive groups. Group slots at index `grp_cnt_i` and above are ignored, even when they are flagged as branches.
- R4: The line closes once it holds `N_INSTR` instructions. If a group would overflow the line, only its leading slots that fit are taken, and the rest of the group (branches included) is dropped.
- R5: The line closes when the `M_BR`-th branch is accepted, and that branch is the last entry of the line.
- R6: `wr_br_cnt_o` gives the number of branches in the line. Bit j of `wr_br_flags_o` is the predicted direction of the j-th branch (1 = taken, 0 = not taken), and bits j ≥ `wr_br_cnt_o` are 0.
- R7: If the last entry is a branch, `wr_target_o` is that slot's predicted target and `wr_fall_o` is its PC + 4.
- R8: If the last entry is not a branch, both `wr_target_o` and `wr_fall_o` equal its PC + 4.
- R9: An abort drops the partial line. No write follows, `busy_o` returns to 0, and any abort takes precedence over a miss or a group in the same cycle.
- R10: `wr_valid_o` is a one-cycle pulse that appears in the cycle after the closing group, with the unit already idle. A miss in that pulse cycle starts the next collection.
- R11: Fetch groups that arrive while no collection is running are ignored and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_i | input | 1 | Trace cache miss, starts a collection |
| miss_pc_i | input | PC_W | Start PC of the new trace |
| abort_i | input | 1 | Drop the partial trace |
| grp_valid_i | input | 1 | Fetch group present |
| grp_cnt_i | input | $clog2(FETCH_W+1) | Number of valid slots in the group |
| grp_pc_i | input | FETCH_W*PC_W | PC of each slot |
| grp_instr_i | input | FETCH_W*INSTR_W | Instruction word of each slot |
| grp_is_br_i | input | FETCH_W | Slot is a conditional branch |
| grp_taken_i | input | FETCH_W | Predicted direction of each slot |
| grp_tgt_i | input | FETCH_W*PC_W | Predicted taken target of each slot |
| busy_o | output | 1 | Collection in progress |
| wr_valid_o | output | 1 | Trace line write pulse |
| wr_tag_o | output | PC_W | Line tag |
| wr_len_o | output | $clog2(N_INSTR+1) | Instructions in the line |
| wr_instr_o | output | N_INSTR*INSTR_W | Line contents |
| wr_br_cnt_o | output | $clog2(M_BR+1) | Branches in the line |
| wr_br_flags_o | output | M_BR | Branch directions |
| wr_target_o | output | PC_W | Continuation if the last branch is taken |
| wr_fall_o | output | PC_W | Continuation otherwise |

## Verification
Two events can fall in the same cycle: the write pulse of a finished line, and the miss that starts the next one. The bench closes a line with a group of three branches and raises the next miss in exactly the cycle in which `wr_valid_o` is high. It then expects the pulse to end and `busy_o` to rise on the next cycle. It also expects the following line to carry the new tag, fresh flags and its own length, with nothing left over from the line before.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;
endpackage

// File: rtl/tfu_slot_scan.sv
// Walks the slots of one fetch group against the running line limits.
module tfu_slot_scan #(
  parameter int N_INSTR = 24,
  parameter int M_BR    = 3,
  parameter int FETCH_W = 4,
  localparam int LEN_W  = $clog2(N_INSTR + 1),
  localparam int BC_W   = $clog2(M_BR + 1),
  localparam int CNT_W  = $clog2(FETCH_W + 1),
  localparam int SLOT_W = (FETCH_W > 1) ? $clog2(FETCH_W) : 1
) (
  input  logic [LEN_W-1:0]        len_i,
  input  logic [BC_W-1:0]         bc_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [FETCH_W-1:0]      is_br_i,
  output logic [FETCH_W-1:0]      accept_o,
  output logic [FETCH_W*BC_W-1:0] br_idx_o,
  output logic [SLOT_W-1:0]       last_o,
  output logic                    close_o,
  output logic [LEN_W-1:0]        len_o,
  output logic [BC_W-1:0]         bc_o
);
  int   run_len;
  int   run_bc;
  logic done;

  always_comb begin
    run_len  = int'(len_i);
    run_bc   = int'(bc_i);
    done     = 1'b0;
    accept_o = '0;
    br_idx_o = '0;
    last_o   = '0;
    for (int k = 0; k < FETCH_W; k++) begin
      if (!done && k < int'(cnt_i)) begin
        accept_o[k]                 = 1'b1;
        br_idx_o[k*BC_W +: BC_W]    = BC_W'(run_bc);
        last_o                      = SLOT_W'(k);
        run_len                     = run_len + 1;
        if (is_br_i[k]) run_bc      = run_bc + 1;
        if (run_len >= N_INSTR || run_bc >= M_BR) done = 1'b1;
      end
    end
    close_o = done;
    len_o   = LEN_W'(run_len);
    bc_o    = BC_W'(run_bc);
  end
endmodule

// File: rtl/tfu_line_store.sv
// Holds the line being built: instruction entries and branch direction flags.
module tfu_line_store #(
  parameter int N_INSTR = 24,
  parameter int M_BR    = 3,
  parameter int FETCH_W = 4,
  parameter int INSTR_W = 32,
  localparam int LEN_W  = $clog2(N_INSTR + 1),
  localparam int BC_W   = $clog2(M_BR + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       wr_en_i,
  input  logic [LEN_W-1:0]           base_i,
  input  logic [FETCH_W-1:0]         accept_i,
  input  logic [FETCH_W*INSTR_W-1:0] instr_i,
  input  logic [FETCH_W-1:0]         is_br_i,
  input  logic [FETCH_W-1:0]         taken_i,
  input  logic [FETCH_W*BC_W-1:0]    br_idx_i,
  output logic [N_INSTR*INSTR_W-1:0] line_o,
  output logic [M_BR-1:0]            flags_o
);
  for (genvar i = 0; i < N_INSTR; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_o[i*INSTR_W +: INSTR_W] <= '0;
      end else if (wr_en_i) begin
        for (int k = 0; k < FETCH_W; k++) begin
          if (accept_i[k] && (int'(base_i) + k == i))
            line_o[i*INSTR_W +: INSTR_W] <= instr_i[k*INSTR_W +: INSTR_W];
        end
      end
    end
  end

  for (genvar j = 0; j < M_BR; j++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o[j] <= 1'b0;
      end else if (clear_i) begin
        flags_o[j] <= 1'b0;
      end else if (wr_en_i) begin
        for (int k = 0; k < FETCH_W; k++) begin
          if (accept_i[k] && is_br_i[k] && (int'(br_idx_i[k*BC_W +: BC_W]) == j))
            flags_o[j] <= taken_i[k];
        end
      end
    end
  end
endmodule

// File: rtl/trace_fill_unit.sv
module trace_fill_unit #(
  parameter int N_INSTR = 24,
  parameter int M_BR    = 3,
  parameter int FETCH_W = 4,
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            miss_i,
  input  logic [PC_W-1:0]                 miss_pc_i,
  input  logic                            abort_i,
  input  logic                            grp_valid_i,
  input  logic [$clog2(FETCH_W+1)-1:0]    grp_cnt_i,
  input  logic [FETCH_W*PC_W-1:0]         grp_pc_i,
  input  logic [FETCH_W*INSTR_W-1:0]      grp_instr_i,
  input  logic [FETCH_W-1:0]              grp_is_br_i,
  input  logic [FETCH_W-1:0]              grp_taken_i,
  input  logic [FETCH_W*PC_W-1:0]         grp_tgt_i,
  output logic                            busy_o,
  output logic                            wr_valid_o,
  output logic [PC_W-1:0]                 wr_tag_o,
  output logic [$clog2(N_INSTR+1)-1:0]    wr_len_o,
  output logic [N_INSTR*INSTR_W-1:0]      wr_instr_o,
  output logic [$clog2(M_BR+1)-1:0]       wr_br_cnt_o,
  output logic [M_BR-1:0]                 wr_br_flags_o,
  output logic [PC_W-1:0]                 wr_target_o,
  output logic [PC_W-1:0]                 wr_fall_o
);
  import tfu_pkg::*;

  localparam int LEN_W  = $clog2(N_INSTR + 1);
  localparam int BC_W   = $clog2(M_BR + 1);
  localparam int SLOT_W = (FETCH_W > 1) ? $clog2(FETCH_W) : 1;

  fill_state_e         state_q;
  logic [PC_W-1:0]     tag_q, tgt_q, fall_q;
  logic [LEN_W-1:0]    len_q, nxt_len;
  logic [BC_W-1:0]     bc_q, nxt_bc;
  logic                wr_valid_q;
  logic                start, take, close;
  logic [FETCH_W-1:0]  accept;
  logic [FETCH_W*BC_W-1:0] br_idx;
  logic [SLOT_W-1:0]   last_slot;
  logic [PC_W-1:0]     last_pc, last_tgt, end_fall, end_tgt;
  logic                last_br;

  // abort wins over miss, miss wins over a group
  assign start = miss_i && !abort_i;
  assign take  = (state_q == FILL_BUSY) && grp_valid_i && !abort_i && !miss_i;

  tfu_slot_scan #(
    .N_INSTR(N_INSTR), .M_BR(M_BR), .FETCH_W(FETCH_W)
  ) u_scan (
    .len_i   (len_q),
    .bc_i    (bc_q),
    .cnt_i   (grp_cnt_i),
    .is_br_i (grp_is_br_i),
    .accept_o(accept),
    .br_idx_o(br_idx),
    .last_o  (last_slot),
    .close_o (close),
    .len_o   (nxt_len),
    .bc_o    (nxt_bc)
  );

  tfu_line_store #(
    .N_INSTR(N_INSTR), .M_BR(M_BR), .FETCH_W(FETCH_W), .INSTR_W(INSTR_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .wr_en_i (take),
    .base_i  (len_q),
    .accept_i(accept),
    .instr_i (grp_instr_i),
    .is_br_i (grp_is_br_i),
    .taken_i (grp_taken_i),
    .br_idx_i(br_idx),
    .line_o  (wr_instr_o),
    .flags_o (wr_br_flags_o)
  );

  always_comb begin
    last_pc  = '0;
    last_tgt = '0;
    last_br  = 1'b0;
    for (int k = 0; k < FETCH_W; k++) begin
      if (SLOT_W'(k) == last_slot) begin
        last_pc  = grp_pc_i[k*PC_W +: PC_W];
        last_tgt = grp_tgt_i[k*PC_W +: PC_W];
        last_br  = grp_is_br_i[k];
      end
    end
    end_fall = last_pc + PC_W'(4);
    end_tgt  = last_br ? last_tgt : end_fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FILL_IDLE;
      tag_q      <= '0;
      len_q      <= '0;
      bc_q       <= '0;
      tgt_q      <= '0;
      fall_q     <= '0;
      wr_valid_q <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      if (abort_i) begin
        state_q <= FILL_IDLE;
      end else if (start) begin
        state_q <= FILL_BUSY;
        tag_q   <= miss_pc_i;
        len_q   <= '0;
        bc_q    <= '0;
      end else if (take) begin
        len_q <= nxt_len;
        bc_q  <= nxt_bc;
        if (close) begin
          state_q    <= FILL_IDLE;
          wr_valid_q <= 1'b1;
          tgt_q      <= end_tgt;
          fall_q     <= end_fall;
        end
      end
    end
  end

  assign busy_o      = (state_q == FILL_BUSY);
  assign wr_valid_o  = wr_valid_q;
  assign wr_tag_o    = tag_q;
  assign wr_len_o    = len_q;
  assign wr_br_cnt_o = bc_q;
  assign wr_target_o = tgt_q;
  assign wr_fall_o   = fall_q;
endmodule

// File: rtl/tfu_checker.sv
module tfu_checker #(
  parameter int N_INSTR = 24,
  parameter int M_BR    = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         miss_i,
  input logic                         abort_i,
  input logic                         busy_o,
  input logic                         wr_valid_o,
  input logic [$clog2(N_INSTR+1)-1:0] wr_len_o,
  input logic [$clog2(M_BR+1)-1:0]    wr_br_cnt_o,
  input logic [M_BR-1:0]              wr_br_flags_o
);
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r10_idle_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !busy_o);

  a_r4_r5_close_on_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (int'(wr_len_o) == N_INSTR || int'(wr_br_cnt_o) == M_BR));

  a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_len_o) <= N_INSTR);

  a_r6_flags_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ((wr_br_flags_o >> wr_br_cnt_o) == '0));

  a_r9_abort_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!wr_valid_o && !busy_o));

  a_r2_miss_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !abort_i) |=> busy_o);
endmodule

bind trace_fill_unit tfu_checker #(.N_INSTR(N_INSTR), .M_BR(M_BR)) u_tfu_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .miss_i       (miss_i),
  .abort_i      (abort_i),
  .busy_o       (busy_o),
  .wr_valid_o   (wr_valid_o),
  .wr_len_o     (wr_len_o),
  .wr_br_cnt_o  (wr_br_cnt_o),
  .wr_br_flags_o(wr_br_flags_o)
);

// File: tb/trace_fill_unit_tb_top.sv
module trace_fill_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 24;
  localparam int M   = 3;
  localparam int FW  = 4;
  localparam int PW  = 32;
  localparam int IW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                 miss_i = 1'b0;
  logic [PW-1:0]        miss_pc = '0;
  logic                 abort_i = 1'b0;
  logic                 grp_valid = 1'b0;
  logic [2:0]           grp_cnt = '0;
  logic [FW*PW-1:0]     grp_pc = '0;
  logic [FW*IW-1:0]     grp_instr = '0;
  logic [FW-1:0]        grp_br = '0;
  logic [FW-1:0]        grp_tk = '0;
  logic [FW*PW-1:0]     grp_tgt = '0;
  logic                 busy, wr_valid;
  logic [PW-1:0]        wr_tag, wr_target, wr_fall;
  logic [4:0]           wr_len;
  logic [N*IW-1:0]      wr_instr;
  logic [1:0]           wr_bc;
  logic [M-1:0]         wr_flags;

  trace_fill_unit #(.N_INSTR(N), .M_BR(M), .FETCH_W(FW), .PC_W(PW), .INSTR_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .miss_i(miss_i), .miss_pc_i(miss_pc), .abort_i(abort_i),
    .grp_valid_i(grp_valid), .grp_cnt_i(grp_cnt), .grp_pc_i(grp_pc), .grp_instr_i(grp_instr),
    .grp_is_br_i(grp_br), .grp_taken_i(grp_tk), .grp_tgt_i(grp_tgt),
    .busy_o(busy), .wr_valid_o(wr_valid), .wr_tag_o(wr_tag), .wr_len_o(wr_len),
    .wr_instr_o(wr_instr), .wr_br_cnt_o(wr_bc), .wr_br_flags_o(wr_flags),
    .wr_target_o(wr_target), .wr_fall_o(wr_fall)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference model state
  bit            m_active = 1'b0;
  bit            m_closed = 1'b0;
  int            m_len, m_bc;
  logic [M-1:0]  m_flags;
  logic [PW-1:0] m_tag, m_tgt, m_fall;
  logic [IW-1:0] m_ins [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] ins_of(input logic [PW-1:0] pc);
    return {8'hC3, pc[23:0]};
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_miss(input logic [PW-1:0] pc);
    miss_i = 1'b1; miss_pc = pc;
    m_active = 1'b1; m_closed = 1'b0; m_len = 0; m_bc = 0; m_flags = '0; m_tag = pc;
    @(negedge clk);
    miss_i = 1'b0;
    chk(busy == 1'b1, "R2", "busy after miss", 64'(busy), 64'd1);
    chk(wr_valid == 1'b0, "R10", "no pulse after miss", 64'(wr_valid), 64'd0);
  endtask

  task automatic do_abort();
    abort_i = 1'b1;
    m_active = 1'b0;
    @(negedge clk);
    abort_i = 1'b0;
    chk(busy == 1'b0, "R9", "busy after abort", 64'(busy), 64'd0);
    chk(wr_valid == 1'b0, "R9", "no write on abort", 64'(wr_valid), 64'd0);
  endtask

  task automatic check_write(input string req_lim);
    bit ins_ok;
    ins_ok = 1'b1;
    chk(wr_valid == 1'b1, "R10", "write pulse", 64'(wr_valid), 64'd1);
    chk(wr_tag == m_tag, "R2", "tag", 64'(wr_tag), 64'(m_tag));
    chk(int'(wr_len) == m_len, req_lim, "length", 64'(wr_len), 64'(m_len));
    for (int i = 0; i < m_len; i++)
      if (wr_instr[i*IW +: IW] !== m_ins[i]) ins_ok = 1'b0;
    chk(ins_ok, "R3", "instruction order", 64'(ins_ok), 64'd1);
    chk(int'(wr_bc) == m_bc, "R6", "branch count", 64'(wr_bc), 64'(m_bc));
    chk(wr_flags == m_flags, "R6", "branch flags", 64'(wr_flags), 64'(m_flags));
    chk(wr_target == m_tgt, "R7/R8", "target addr", 64'(wr_target), 64'(m_tgt));
    chk(wr_fall == m_fall, "R7/R8", "fall-through addr", 64'(wr_fall), 64'(m_fall));
  endtask

  // consecutive PCs from pc0; every slot gets the same predicted target
  task automatic send_group(input logic [PW-1:0] pc0, input int cnt, input logic [FW-1:0] brm,
                            input logic [FW-1:0] tkm, input logic [PW-1:0] tgt,
                            input string req_lim);
    bit closed_now;
    closed_now = 1'b0;
    grp_valid = 1'b1; grp_cnt = 3'(cnt); grp_br = brm; grp_tk = tkm;
    for (int k = 0; k < FW; k++) begin
      grp_pc[k*PW +: PW]    = pc0 + 32'(4*k);
      grp_instr[k*IW +: IW] = ins_of(pc0 + 32'(4*k));
      grp_tgt[k*PW +: PW]   = tgt;
    end
    for (int k = 0; k < cnt; k++) begin
      if (m_active) begin
        m_ins[m_len] = ins_of(pc0 + 32'(4*k));
        m_len++;
        if (brm[k]) begin m_flags[m_bc] = tkm[k]; m_bc++; end
        if (m_len == N || m_bc == M) begin
          m_active = 1'b0; closed_now = 1'b1;
          m_fall = pc0 + 32'(4*k) + 32'd4;
          m_tgt  = brm[k] ? tgt : m_fall;
        end
      end
    end
    @(negedge clk);
    grp_valid = 1'b0;
    if (closed_now) check_write(req_lim);
    else chk(wr_valid == 1'b0, "R11", "no write before limit", 64'(wr_valid), 64'd0);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
    chk(wr_valid == 1'b0, "R1", "wr_valid in reset", 64'(wr_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && wr_valid == 1'b0, "R1", "idle after reset", 64'({busy, wr_valid}), 64'd0);
  endtask

  task automatic t_idle_groups();
    // R11: groups with branches, no collection running
    send_group(32'h0000_0800, 4, 4'b1111, 4'b1111, 32'h0000_0900, "R11");
    send_group(32'h0000_0810, 3, 4'b0111, 4'b0000, 32'h0000_0900, "R11");
    chk(busy == 1'b0, "R11", "still idle", 64'(busy), 64'd0);
  endtask

  task automatic t_branch_limit();
    // R5 R6 R7: three branches spread over four groups; slot 3 of group 2 beyond cnt
    do_miss(32'h0000_1000);
    send_group(32'h0000_1000, 4, 4'b0000, 4'b0000, 32'h0, "R5");
    send_group(32'h0000_1010, 3, 4'b1100, 4'b0100, 32'h0000_2000, "R5");
    send_group(32'h0000_2000, 4, 4'b0010, 4'b0000, 32'h0000_2400, "R5");
    send_group(32'h0000_2010, 4, 4'b0010, 4'b0010, 32'h0000_3000, "R5");
    chk(wr_target == 32'h0000_3000, "R7", "taken target", 64'(wr_target), 64'h3000);
    chk(wr_flags == 3'b101, "R6", "flag pattern", 64'(wr_flags), 64'h5);
    @(negedge clk);
    chk(wr_valid == 1'b0, "R10", "pulse one cycle", 64'(wr_valid), 64'd0);
  endtask

  task automatic t_instr_limit();
    // R4 R8: exactly N straight-line instructions
    do_miss(32'h0000_4000);
    for (int g = 0; g < 6; g++)
      send_group(32'h0000_4000 + 32'(16*g), 4, 4'b0000, 4'b0000, 32'h0, "R4");
    chk(wr_target == 32'h0000_4060 && wr_fall == 32'h0000_4060, "R8", "sequential end",
        64'(wr_target), 64'h4060);
    @(negedge clk);
  endtask

  task automatic t_overflow();
    // R4 R7: last group partially taken, its trailing branch dropped
    do_miss(32'h0000_5000);
    for (int g = 0; g < 5; g++)
      send_group(32'h0000_5000 + 32'(16*g), 4, 4'b0000, 4'b0000, 32'h0, "R4");
    send_group(32'h0000_5050, 3, 4'b0000, 4'b0000, 32'h0, "R4");
    send_group(32'h0000_505C, 4, 4'b0011, 4'b0000, 32'h0000_6000, "R4");
    chk(int'(wr_bc) == 1, "R4", "dropped branch not counted", 64'(wr_bc), 64'd1);
    chk(wr_fall == 32'h0000_5060, "R7", "fall-through of last branch", 64'(wr_fall), 64'h5060);
    @(negedge clk);
  endtask

  task automatic t_abort();
    // R9: partial line dropped, following groups ignored
    do_miss(32'h0000_B000);
    send_group(32'h0000_B000, 4, 4'b0001, 4'b0001, 32'h0000_C000, "R9");
    do_abort();
    send_group(32'h0000_C000, 4, 4'b0111, 4'b0111, 32'h0000_D000, "R9");
    repeat (2) @(negedge clk);
    chk(wr_valid == 1'b0 && busy == 1'b0, "R9", "quiet after abort", 64'({busy, wr_valid}), 64'd0);
  endtask

  task automatic t_back_to_back();
    // R10: miss raised in the write pulse cycle
    do_miss(32'h0000_7000);
    send_group(32'h0000_7000, 3, 4'b0111, 4'b0100, 32'h0000_8000, "R5");
    do_miss(32'h0000_9000);
    send_group(32'h0000_9000, 3, 4'b0111, 4'b0011, 32'h0000_A000, "R10");
    chk(wr_tag == 32'h0000_9000 && wr_flags == 3'b011, "R10", "next line state",
        64'({wr_tag, 5'd0, wr_flags}), 64'({32'h9000, 8'h03}));
    chk(wr_target == 32'h0000_A000 && wr_fall == 32'h0000_900C, "R7", "branch end addrs",
        64'({wr_target, wr_fall}), 64'({32'hA000, 32'h900C}));
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle_groups();
    t_branch_limit();
    t_instr_limit();
    t_overflow();
    t_abort();
    t_back_to_back();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule